// File: doc/BRIEF.md
# Comma Framer with Ready Flag

This block sits on the receive side of a 10-bit coded serial link, behind clock recovery. It takes one serial bit per cycle in which the bit-clock enable is high. It hunts for either polarity of the K28.5 comma, and when it finds one it moves the 10-bit symbol boundary onto that comma. Every later symbol is cut at that boundary. It drives each aligned symbol out in parallel with a comma flag, a byte-rate clock at one tenth of the bit rate, and an active-low ready flag. Decoding the symbols is left to the logic downstream.

The framer can be switched on and off with an enable input. That input is sampled only at the falling edge of the byte-rate clock. While the framer is off, the current boundary is kept and commas never move it.

Ready is a framing-status flag. It stays high until a comma has been found while the framer was on. After that it marks each presented symbol as valid, except inside a run of back-to-back commas. In such a run, only the last comma of the run (or a lone comma) is flagged. To know whether a comma is the last of its run, each symbol is held for one slot and compared with the next one. This costs one symbol of output latency.

Top module: `cmf_framer_top`

## Requirements
- R1: While the latched enable is high, a completed 10-bit window equal to 0011111010 or 1100000101 ends a symbol at once. In each window the bit received first is the leftmost, and it is placed at sym_out[9]. From then on, every symbol spans the next 10 enabled bits.
- R2: While the latched enable is low, no comma moves the boundary. A symbol ends only after 10 enabled bits.
- R3: frm_en is latched only at the byte_clk falling edge, which comes with the fifth enabled bit of a slot. A change at any other time has no effect until the next such edge.
- R4: byte_clk is high after the first five enabled bits of a slot (counting the boundary bit) and low after the last five. It returns high at each symbol boundary.
- R5: sym_out shows an aligned symbol from the boundary at which the following symbol completes until the next boundary. The bit received first is at bit 9.
- R6: comma_out is high exactly when the symbol on sym_out is one of the two comma patterns.
- R7: rdy_n stays high for every symbol that completed before the first comma found with the latched enable high. It is low for every later data symbol.
- R8: A presented comma whose successor symbol is also a comma has rdy_n high. A lone comma, or the last comma of a run, has rdy_n low.
- R9: In a cycle with bit_en low, nothing changes: ser_in is ignored and sym_out, comma_out, rdy_n and byte_clk hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | High in a cycle that carries a serial bit |
| ser_in | input | 1 | Serial data bit |
| frm_en | input | 1 | Framer enable, sampled at the byte_clk falling edge |
| sym_out | output | 10 | Aligned symbol, bit received first at bit 9 |
| comma_out | output | 1 | Presented symbol is a comma |
| rdy_n | output | 1 | Active-low ready for the presented symbol |
| byte_clk | output | 1 | Byte-rate clock, bit rate divided by 10 |

## Verification
The assertions check several rules on every cycle:
- no slot ever runs past ten enabled bits;
- an enabled comma always ends a slot, and a disabled framer never cuts a slot short;
- the enable latch moves only when byte_clk falls;
- the outputs hold between boundaries and through idle cycles;
- ready stays high before lock and inside a comma run.

Only the bench scenarios can show that the presented symbols are the right bits, in the right order and with one symbol of latency. The same holds for ready being low for lone and trailing commas, for a boundary being kept after a misaligned comma arrives with the framer off, and for a comma that arrives before the enable is latched being ignored. These scenarios are swept over every starting phase, with and without idle cycles between bits.

// File: rtl/cmf_pkg.sv
package cmf_pkg;
  // Symbol width and the two comma polarities, first-received bit leftmost
  localparam int unsigned CMF_SYM_W = 10;
  localparam logic [CMF_SYM_W-1:0] CMF_COMMA_POS = 10'b0011111010;
  localparam logic [CMF_SYM_W-1:0] CMF_COMMA_NEG = 10'b1100000101;
  localparam int unsigned CMF_N_PAT = 2;
endpackage

// File: rtl/cmf_comma_det.sv
module cmf_comma_det #(
  parameter int unsigned SYM_W = cmf_pkg::CMF_SYM_W,
  parameter logic [SYM_W-1:0] PAT_POS = cmf_pkg::CMF_COMMA_POS,
  parameter logic [SYM_W-1:0] PAT_NEG = cmf_pkg::CMF_COMMA_NEG
) (
  input  logic [SYM_W-1:0] win,
  output logic             hit
);
  localparam int unsigned N_PAT = cmf_pkg::CMF_N_PAT;
  localparam logic [N_PAT-1:0][SYM_W-1:0] PATS = {PAT_NEG, PAT_POS};

  logic [N_PAT-1:0] match;

  for (genvar p = 0; p < N_PAT; p++) begin : g_pat
    always_comb begin
      match[p] = (win == PATS[p]);
    end
  end

  always_comb begin
    hit = |match;
  end
endmodule

// File: rtl/cmf_slot_ctl.sv
module cmf_slot_ctl #(
  parameter int unsigned SYM_W = cmf_pkg::CMF_SYM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             ser_in,
  input  logic             frm_en,
  input  logic             comma_hit,
  output logic [SYM_W-1:0] win_nxt,
  output logic             sym_done,
  output logic             en_q,
  output logic             byte_clk
);
  localparam int unsigned PH_W = $clog2(SYM_W);
  localparam int unsigned HALF = SYM_W / 2;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SYM_W - 1);
  localparam logic [PH_W-1:0] PH_FALL = PH_W'(HALF - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(HALF);

  logic [SYM_W-1:0] win_q, win_d;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic             en_d;
  logic             fall;

  // Next-state logic
  always_comb begin
    win_nxt  = {win_q[SYM_W-2:0], ser_in};
    sym_done = bit_en & ((ph_q == PH_LAST) | (en_q & comma_hit));
    fall     = bit_en & ~sym_done & (ph_q == PH_FALL);
    win_d    = win_q;
    ph_d     = ph_q;
    en_d     = en_q;
    if (bit_en) begin
      win_d = win_nxt;
      ph_d  = sym_done ? '0 : ph_q + 1'b1;
    end
    if (fall) begin
      en_d = frm_en;
    end
    byte_clk = (ph_q < PH_HALF);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      ph_q  <= '0;
      en_q  <= 1'b0;
    end else begin
      win_q <= win_d;
      ph_q  <= ph_d;
      en_q  <= en_d;
    end
  end
endmodule

// File: rtl/cmf_run_filter.sv
module cmf_run_filter #(
  parameter int unsigned SYM_W = cmf_pkg::CMF_SYM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_done,
  input  logic [SYM_W-1:0] win,
  input  logic             win_comma,
  input  logic             en_q,
  output logic [SYM_W-1:0] sym_out,
  output logic             comma_out,
  output logic             rdy_n,
  output logic             locked,
  output logic             hold_k
);
  logic [SYM_W-1:0] hold_sym_q, hold_sym_d;
  logic             hold_k_d;
  logic             hold_v_q, hold_v_d;
  logic             lock_q, lock_d;
  logic [SYM_W-1:0] out_sym_q, out_sym_d;
  logic             out_k_q, out_k_d;
  logic             rdy_n_q, rdy_n_d;
  logic             hold_k_q;

  // Next-state logic
  always_comb begin
    lock_d     = lock_q;
    hold_sym_d = hold_sym_q;
    hold_k_d   = hold_k_q;
    hold_v_d   = hold_v_q;
    out_sym_d  = out_sym_q;
    out_k_d    = out_k_q;
    rdy_n_d    = rdy_n_q;
    if (sym_done) begin
      lock_d     = lock_q | (en_q & win_comma);
      hold_sym_d = win;
      hold_k_d   = win_comma;
      hold_v_d   = lock_d;
      out_sym_d  = hold_sym_q;
      out_k_d    = hold_k_q;
      // Suppress a held comma when the next symbol is a comma as well
      rdy_n_d    = ~(hold_v_q & ~(hold_k_q & win_comma));
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q     <= 1'b0;
      hold_sym_q <= '0;
      hold_k_q   <= 1'b0;
      hold_v_q   <= 1'b0;
      out_sym_q  <= '0;
      out_k_q    <= 1'b0;
      rdy_n_q    <= 1'b1;
    end else begin
      lock_q     <= lock_d;
      hold_sym_q <= hold_sym_d;
      hold_k_q   <= hold_k_d;
      hold_v_q   <= hold_v_d;
      out_sym_q  <= out_sym_d;
      out_k_q    <= out_k_d;
      rdy_n_q    <= rdy_n_d;
    end
  end

  always_comb begin
    sym_out   = out_sym_q;
    comma_out = out_k_q;
    rdy_n     = rdy_n_q;
    locked    = lock_q;
    hold_k    = hold_k_q;
  end
endmodule

// File: rtl/cmf_framer_top.sv
module cmf_framer_top #(
  parameter int unsigned SYM_W = cmf_pkg::CMF_SYM_W,
  parameter logic [SYM_W-1:0] PAT_POS = cmf_pkg::CMF_COMMA_POS,
  parameter logic [SYM_W-1:0] PAT_NEG = cmf_pkg::CMF_COMMA_NEG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             ser_in,
  input  logic             frm_en,
  output logic [SYM_W-1:0] sym_out,
  output logic             comma_out,
  output logic             rdy_n,
  output logic             byte_clk
);
  logic [SYM_W-1:0] win_nxt;
  logic             comma_hit;
  logic             sym_done;
  logic             en_q;
  logic             locked;
  logic             hold_k;

  cmf_slot_ctl #(.SYM_W(SYM_W)) slot_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .ser_in    (ser_in),
    .frm_en    (frm_en),
    .comma_hit (comma_hit),
    .win_nxt   (win_nxt),
    .sym_done  (sym_done),
    .en_q      (en_q),
    .byte_clk  (byte_clk)
  );

  cmf_comma_det #(.SYM_W(SYM_W), .PAT_POS(PAT_POS), .PAT_NEG(PAT_NEG)) det_i (
    .win (win_nxt),
    .hit (comma_hit)
  );

  cmf_run_filter #(.SYM_W(SYM_W)) filt_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_done  (sym_done),
    .win       (win_nxt),
    .win_comma (comma_hit),
    .en_q      (en_q),
    .sym_out   (sym_out),
    .comma_out (comma_out),
    .rdy_n     (rdy_n),
    .locked    (locked),
    .hold_k    (hold_k)
  );
endmodule

// File: rtl/cmf_framer_chk.sv
module cmf_framer_chk #(
  parameter int unsigned SYM_W = cmf_pkg::CMF_SYM_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_en,
  input logic             sym_done,
  input logic             comma_hit,
  input logic             en_q,
  input logic             locked,
  input logic             hold_k,
  input logic [SYM_W-1:0] sym_out,
  input logic             comma_out,
  input logic             rdy_n,
  input logic             byte_clk
);
  localparam int unsigned CW = $clog2(SYM_W + 1);
  localparam logic [CW-1:0] C_LAST = CW'(SYM_W - 1);

  logic [CW-1:0] bits_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
    end else if (bit_en) begin
      bits_q <= sym_done ? '0 : bits_q + 1'b1;
    end
  end

  AST_SLOT_MAX_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && bits_q == C_LAST) |-> sym_done); // R1
  AST_REALIGN_ON_COMMA: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && en_q && comma_hit) |-> sym_done); // R1
  AST_NO_EARLY_CUT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && bits_q != C_LAST) |-> !sym_done); // R2
  AST_EN_LATCH_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(en_q) |-> $fell(byte_clk)); // R3
  AST_HOLD_BETWEEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_done |=> ($stable(sym_out) && $stable(comma_out) && $stable(rdy_n))); // R5
  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(sym_out) && $stable(byte_clk) && $stable(rdy_n))); // R9
  AST_NO_READY_BEFORE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> rdy_n); // R7
  AST_RUN_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_done && hold_k && comma_hit) |=> (rdy_n && comma_out)); // R8
endmodule

bind cmf_framer_top cmf_framer_chk #(.SYM_W(SYM_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_en    (bit_en),
  .sym_done  (sym_done),
  .comma_hit (comma_hit),
  .en_q      (en_q),
  .locked    (locked),
  .hold_k    (hold_k),
  .sym_out   (sym_out),
  .comma_out (comma_out),
  .rdy_n     (rdy_n),
  .byte_clk  (byte_clk)
);

// File: tb/cmf_framer_top_tb_top.sv
module cmf_framer_top_tb_top;
  localparam int MAXB = 400;
  localparam logic [9:0] KP = 10'b0011111010;
  localparam logic [9:0] KN = 10'b1100000101;

  logic       clk;
  logic       rst_n;
  logic       bit_en;
  logic       ser_in;
  logic       frm_en;
  logic [9:0] sym_out;
  logic       comma_out;
  logic       rdy_n;
  logic       byte_clk;

  int  n_chk;
  int  n_err;
  bit  finished;
  logic arr [MAXB];
  logic ena [MAXB];
  int  nb;

  cmf_framer_top dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ser_in(ser_in), .frm_en(frm_en),
    .sym_out(sym_out), .comma_out(comma_out), .rdy_n(rdy_n), .byte_clk(byte_clk)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit is_k(input logic [9:0] w);
    return (w == KP) || (w == KN);
  endfunction

  function automatic logic [9:0] win_at(input int p);
    logic [9:0] w;
    for (int j = 0; j < 10; j++) w[9-j] = arr[p-9+j];
    return w;
  endfunction

  task automatic push_bit(input logic b, input logic e);
    arr[nb] = b;
    ena[nb] = e;
    nb++;
  endtask

  task automatic push_sym(input logic [9:0] w, input logic e);
    for (int j = 9; j >= 0; j--) push_bit(w[j], e);
  endtask

  task automatic do_reset();
    rst_n  = 1'b0;
    bit_en = 1'b0;
    ser_in = 1'b0;
    frm_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(rdy_n == 1'b1 && comma_out == 1'b0, "R7 reset rdy/comma", {8'd0, rdy_n, comma_out}, 10'b10);
    chk(sym_out == 10'd0, "R5 reset sym", sym_out, 10'd0);
    chk(byte_clk == 1'b1, "R4 reset byte_clk", {9'd0, byte_clk}, 10'd1);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_pass(input int off, input bit gap, input bit late);
    int e0;
    logic [9:0] w, wn;
    logic [9:0] s_sym;
    logic s_rdy, s_k, s_bc;
    nb = 0;
    if (late) begin
      for (int j = 0; j < 5; j++) push_bit(1'b0, 1'b0);
      push_sym(KP, 1'b1);              // decoy before enable is latched (R3)
      for (int j = 0; j < 3 + off; j++) push_bit(1'b0, 1'b1);
    end else begin
      for (int j = 0; j < 10 + off; j++) push_bit(1'b0, 1'b1);
    end
    e0 = nb + 9;
    push_sym(KP, 1'b1);
    push_sym(10'b1010101010, 1'b1);
    push_sym(10'b1101001011, 1'b1);
    push_sym(KN, 1'b1);
    push_sym(KP, 1'b1);
    push_sym(KN, 1'b1);
    push_sym(10'b0110100101, 1'b1);
    push_sym(KP, 1'b1);
    push_sym(10'b1001011010, 1'b0);    // framer off from here (R2)
    push_sym(10'b0101101100, 1'b0);
    push_bit(1'b1, 1'b0); push_bit(1'b0, 1'b0); push_bit(1'b1, 1'b0);
    push_sym(KP, 1'b0);                // misaligned comma, must be ignored
    push_sym(10'b1011001101, 1'b0);
    push_sym(10'b0100110100, 1'b0);
    push_sym(10'b1010010110, 1'b0);
    push_sym(10'b1010101010, 1'b0);
    push_sym(10'b1010101010, 1'b0);

    do_reset();
    for (int i = 0; i < nb; i++) begin
      ser_in = arr[i];
      frm_en = ena[i];
      bit_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      if (i < e0 + 10)
        chk(rdy_n == 1'b1, "R7 no ready before lock", {9'd0, rdy_n}, 10'd1);
      if (i >= e0)
        chk(byte_clk == (((i - e0) % 10) < 5), "R4 byte_clk phase", {9'd0, byte_clk},
            {9'd0, 1'(((i - e0) % 10) < 5)});
      if (i >= e0 + 10 && ((i - e0) % 10) == 0) begin
        w  = win_at(i - 10);
        wn = win_at(i);
        chk(sym_out == w, "R1 R2 R5 aligned symbol", sym_out, w);
        chk(comma_out == is_k(w), "R6 comma flag", {9'd0, comma_out}, {9'd0, is_k(w)});
        if (is_k(w))
          chk(rdy_n == (is_k(w) && is_k(wn)), "R8 comma run ready", {9'd0, rdy_n},
              {9'd0, 1'(is_k(w) && is_k(wn))});
        else
          chk(rdy_n == 1'b0, "R7 data ready", {9'd0, rdy_n}, 10'd0);
      end
      if (gap) begin
        s_sym = sym_out; s_rdy = rdy_n; s_k = comma_out; s_bc = byte_clk;
        bit_en = 1'b0;
        ser_in = ~ser_in;
        @(posedge clk);
        @(negedge clk);
        chk(sym_out == s_sym && rdy_n == s_rdy && comma_out == s_k && byte_clk == s_bc,
            "R9 idle cycle hold", {sym_out[6:0], rdy_n, comma_out, byte_clk},
            {s_sym[6:0], s_rdy, s_k, s_bc});
      end
    end
    bit_en = 1'b0;
  endtask

  initial begin
    n_chk = 0;
    n_err = 0;
    finished = 1'b0;
    for (int pass = 0; pass < 20; pass++)
      run_pass(pass % 10, pass >= 10, (pass % 2) == 1);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule